// File: doc/BRIEF.md
# Mixed-Radix Bus Cycle Timer

A free-running isochronous cycle timer. One input, `tick_en`, marks each tick of a 24.576 MHz time base. The timer keeps three fields in one 32-bit word. The lowest field counts ticks within a bus cycle. The middle field counts bus cycles within a second. The top field counts seconds. Each field wraps at its own modulus: 3072 ticks per cycle, 8000 cycles per second and 128 seconds per range. Moduli that are not powers of two give an odd carry pattern, and consumers of the value must allow for it.

Software can load the whole word in one clock through a load strobe. A field value that lies outside its range is forced to zero as it is loaded. The timer also gives the same time as a flat count of ticks since zero, so comparison logic downstream need not decode the fields. A one-cycle event marks each 64-second boundary that the counting crosses. The top bit of the word tells the first half of the 128-second range from the second half.

Top module: `bus_cycle_timer`

## Requirements
- R1: With `tick_en` high and `load_en` low, the offset field (bits 11:0) increases by one at the clock edge. With both `tick_en` and `load_en` low, the whole word `cyc_time` holds its value.
- R2: The offset field counts 0 to 3071. A tick at 3071 returns it to 0 and carries into the cycle field.
- R3: The cycle field (bits 24:12) counts 0 to 7999 and advances only on an offset carry. A carry at 7999 returns it to 0 and carries into the seconds field.
- R4: The seconds field (bits 31:25) advances only on a cycle carry. It wraps from 127 to 0 with no other effect.
- R5: A carry through all fields happens at one clock edge. For example, 63:7999:3071 becomes 64:0:0 in a single step, with no intermediate value.
- R6: `sec64_evt` goes high for exactly one clock cycle, in the cycle right after an edge at which counting moved the seconds field from 63 to 64 or from 127 to 0. It is low at all other times. Bit 31 of `cyc_time` is 0 for seconds 0 to 63 and 1 for seconds 64 to 127.
- R7: When `load_en` is high, the whole word takes `load_val` at the clock edge, and `tick_en` in that cycle has no effect.
- R8: When loading, an offset of 3072 or more is stored as 0 and a cycle value of 8000 or more is stored as 0. Each field is checked on its own. A load never raises `sec64_evt`.
- R9: `lin_ticks` equals offset + 3072 × cycle + 24,576,000 × seconds for the current `cyc_time`, in the same clock cycle.
- R10: Reset is synchronous and active low (`rst_n` = 0). It clears `cyc_time` to zero and holds `sec64_evt` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One 24.576 MHz time-base tick in this clock |
| load_en | input | 1 | Load strobe for the whole timer word |
| load_val | input | 32 | Value to load: seconds[31:25], cycle[24:12], offset[11:0] |
| cyc_time | output | 32 | Packed timer: seconds[31:25], cycle[24:12], offset[11:0] |
| lin_ticks | output | 32 | Same time as a flat tick count |
| sec64_evt | output | 1 | One-cycle event on each 64-second boundary crossed by counting |

## Verification
The assertions check the following on every clock:
- Each field stays inside its range.
- A lone tick advances only the offset.
- An offset carry advances the cycle field.
- An idle clock holds the word.
- An in-range load is taken exactly.
- The event appears only when the low six seconds bits are zero, and never in two cycles in a row.

Some behaviour only the bench scenarios can show:
- The flat tick value, which is compared against a model computed independently of the design.
- Clamping of out-of-range loads.
- The full 127:7999:3071 rollover to zero.
- That a load, even onto a boundary, never raises the event.

// File: rtl/bct_pkg.sv
// Package: field layout shared by the cycle timer and its checker.
// Assumes the packed word is seconds | cycle | offset, from MSB down to LSB.
package bct_pkg;
    localparam int OFS_W  = 12;
    localparam int CNT_W  = 13;
    localparam int SEC_W  = 7;
    localparam int TIME_W = OFS_W + CNT_W + SEC_W;
    localparam int OFS_LO = 0;
    localparam int CNT_LO = OFS_W;
    localparam int SEC_LO = OFS_W + CNT_W;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
        logic [OFS_W-1:0] ofs;
    } cyc_word_t;
endpackage

// File: rtl/bct_mod_counter.sv
// Module: one field of the timer, a counter modulo MODULUS with carry in/out.
// Assumes MODULUS <= 2**WIDTH. A load takes priority over a carry in.
// A loaded value of MODULUS or more is replaced by zero.
module bct_mod_counter #(
    parameter int WIDTH   = 12,
    parameter int MODULUS = 3072
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] val,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] ld_fix;

    // Clamp logic exists only when the modulus leaves unused codes
    generate
        if (MODULUS == (1 << WIDTH)) begin : g_full
            assign ld_fix = ld_val;
        end else begin : g_clamp
            assign ld_fix = (ld_val > LAST) ? '0 : ld_val;
        end
    endgenerate

    // Carry out when this field is advanced from its last value
    assign wrap = inc && !ld && (val_q == LAST);

    // Field register: reset, load, or advance modulo MODULUS
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_q <= '0;
        else if (ld)
            val_q <= ld_fix;
        else if (inc)
            val_q <= (val_q == LAST) ? '0 : val_q + 1'b1;
    end

    assign val = val_q;
endmodule

// File: rtl/bct_linear.sv
// Module: converts the packed fields to a flat tick count (combinational).
// Assumes the result fits in TIME_W bits for the largest legal value.
module bct_linear
    import bct_pkg::*;
#(
    parameter int OFS_MOD = 3072,
    parameter int CNT_MOD = 8000
) (
    input  cyc_word_t          word,
    output logic [TIME_W-1:0]  ticks
);
    localparam logic [TIME_W-1:0] K_CNT = TIME_W'(OFS_MOD);
    localparam logic [TIME_W-1:0] K_SEC = TIME_W'(OFS_MOD * CNT_MOD);

    // Weighted sum of the three fields
    always_comb begin
        ticks = TIME_W'(word.ofs)
              + TIME_W'(word.cnt) * K_CNT
              + TIME_W'(word.sec) * K_SEC;
    end
endmodule

// File: rtl/bct_event.sv
// Module: registered one-cycle event on each half-range seconds boundary.
// Assumes sec_inc is the carry into the seconds field, and sec_wrap is that field's own carry out.
module bct_event
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             sec_inc,
    input  logic             sec_wrap,
    input  logic [SEC_W-1:0] sec,
    output logic             evt
);
    localparam logic [SEC_W-1:0] HALF_LAST = SEC_W'((1 << (SEC_W - 1)) - 1);

    logic evt_d;
    logic evt_q;

    // Crossing into the upper half, or wrapping back to zero
    assign evt_d = !ld && (sec_wrap || (sec_inc && sec == HALF_LAST));

    // Event register, so the pulse lines up with the new seconds value
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else
            evt_q <= evt_d;
    end

    assign evt = evt_q;
endmodule

// File: rtl/bus_cycle_timer.sv
// Module: mixed-radix isochronous cycle timer (offset / cycle / seconds).
// Assumes tick_en marks 24.576 MHz ticks; load_en overrides counting.
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int OFS_MOD = 3072,
    parameter int CNT_MOD = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load_en,
    input  logic [TIME_W-1:0] load_val,
    output logic [TIME_W-1:0] cyc_time,
    output logic [TIME_W-1:0] lin_ticks,
    output logic              sec64_evt
);
    localparam int SEC_MOD = 1 << SEC_W;

    cyc_word_t word;
    logic      ofs_wrap;
    logic      cnt_wrap;
    logic      sec_wrap;

    bct_mod_counter #(.WIDTH(OFS_W), .MODULUS(OFS_MOD)) u_ofs (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick_en),
        .ld     (load_en),
        .ld_val (load_val[OFS_LO +: OFS_W]),
        .val    (word.ofs),
        .wrap   (ofs_wrap)
    );

    bct_mod_counter #(.WIDTH(CNT_W), .MODULUS(CNT_MOD)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ofs_wrap),
        .ld     (load_en),
        .ld_val (load_val[CNT_LO +: CNT_W]),
        .val    (word.cnt),
        .wrap   (cnt_wrap)
    );

    bct_mod_counter #(.WIDTH(SEC_W), .MODULUS(SEC_MOD)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cnt_wrap),
        .ld     (load_en),
        .ld_val (load_val[SEC_LO +: SEC_W]),
        .val    (word.sec),
        .wrap   (sec_wrap)
    );

    bct_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (load_en),
        .sec_inc  (cnt_wrap),
        .sec_wrap (sec_wrap),
        .sec      (word.sec),
        .evt      (sec64_evt)
    );

    bct_linear #(.OFS_MOD(OFS_MOD), .CNT_MOD(CNT_MOD)) u_lin (
        .word  (word),
        .ticks (lin_ticks)
    );

    assign cyc_time = word;
endmodule

// File: rtl/bct_checker.sv
// Module: property checker for bus_cycle_timer, attached by bind.
// Assumes the default field layout from bct_pkg.
module bct_checker
    import bct_pkg::*;
#(
    parameter int OFS_MOD = 3072,
    parameter int CNT_MOD = 8000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              load_en,
    input logic [TIME_W-1:0] load_val,
    input logic [TIME_W-1:0] cyc_time,
    input logic              sec64_evt
);
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(OFS_MOD - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MOD - 1);

    logic [OFS_W-1:0] ofs;
    logic [CNT_W-1:0] cnt;
    logic [SEC_W-1:0] sec;
    assign ofs = cyc_time[OFS_LO +: OFS_W];
    assign cnt = cyc_time[CNT_LO +: CNT_W];
    assign sec = cyc_time[SEC_LO +: SEC_W];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cyc_time == '0 && !sec64_evt)); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_en) |=> $stable(cyc_time)); // R1

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_en && ofs != OFS_LAST) |=>
        (ofs == $past(ofs) + 1'b1 && cnt == $past(cnt) && sec == $past(sec))); // R1

    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ofs <= OFS_LAST); // R2

    AST_CNT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_en && ofs == OFS_LAST && cnt != CNT_LAST) |=>
        (ofs == '0 && cnt == $past(cnt) + 1'b1 && sec == $past(sec))); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST); // R3

    AST_EVT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        sec64_evt |-> (sec[SEC_W-2:0] == '0 && cnt == '0 && ofs == '0)); // R6

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec64_evt |=> !sec64_evt); // R6

    AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_val[OFS_LO +: OFS_W] <= OFS_LAST
                 && load_val[CNT_LO +: CNT_W] <= CNT_LAST) |=>
        (cyc_time == $past(load_val))); // R7

    AST_LOAD_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !sec64_evt); // R8
endmodule

bind bus_cycle_timer bct_checker #(.OFS_MOD(OFS_MOD), .CNT_MOD(CNT_MOD)) u_bct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .load_en   (load_en),
    .load_val  (load_val),
    .cyc_time  (cyc_time),
    .sec64_evt (sec64_evt)
);

// File: tb/test_bus_cycle_timer.sv
// Bench: directed corners plus seeded random ticks and loads, checked against a bench model.
module test_bus_cycle_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic [31:0] cyc_time;
    logic [31:0] lin_ticks;
    logic        sec64_evt;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_time = '0;
    logic        m_evt  = 1'b0;

    bus_cycle_timer i_bus_cycle_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_en   (load_en),
        .load_val  (load_val),
        .cyc_time  (cyc_time),
        .lin_ticks (lin_ticks),
        .sec64_evt (sec64_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack fields into the timer word
    function automatic logic [31:0] pack(int unsigned s, int unsigned c, int unsigned o);
        return {s[6:0], c[12:0], o[11:0]};
    endfunction

    // Flat tick count from fields: o + 3072*c + 24576000*s
    function automatic logic [31:0] flat(logic [31:0] w);
        longint unsigned v;
        v = longint'(w[11:0]) + 64'd3072 * longint'(w[24:12]) + 64'd24576000 * longint'(w[31:25]);
        return v[31:0];
    endfunction

    // Load value with out-of-range fields forced to zero
    function automatic logic [31:0] clamp(logic [31:0] v);
        int unsigned o, c;
        o = v[11:0];
        c = v[24:12];
        if (o >= 3072) o = 0;
        if (c >= 8000) c = 0;
        return pack(v[31:25], c, o);
    endfunction

    task automatic check(string tag);
        logic [31:0] exp_lin;
        exp_lin = flat(m_time);
        n_tests++;
        if (cyc_time !== m_time) begin
            n_fail++;
            $display("FAIL %s cyc_time actual=%08h expected=%08h", tag, cyc_time, m_time);
        end
        n_tests++;
        if (lin_ticks !== exp_lin) begin
            n_fail++;
            $display("FAIL R9 (%s) lin_ticks actual=%0d expected=%0d", tag, lin_ticks, exp_lin);
        end
        n_tests++;
        if (sec64_evt !== m_evt) begin
            n_fail++;
            $display("FAIL R6 (%s) sec64_evt actual=%0b expected=%0b", tag, sec64_evt, m_evt);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(bit tk, bit ld, logic [31:0] v, string tag);
        int unsigned o, c, s;
        tick_en  = tk;
        load_en  = ld;
        load_val = v;
        @(posedge clk);
        m_evt = 1'b0;
        if (ld) begin
            m_time = clamp(v);
        end else if (tk) begin
            o = m_time[11:0];
            c = m_time[24:12];
            s = m_time[31:25];
            if (o == 3071) begin
                o = 0;
                if (c == 7999) begin
                    c = 0;
                    s = (s + 1) % 128;
                    m_evt = (s == 0 || s == 64);
                end else begin
                    c++;
                end
            end else begin
                o++;
            end
            m_time = pack(s, c, o);
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        tick_en = 1'b1;
        load_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        m_time = '0;
        m_evt  = 1'b0;
        @(negedge clk);
        check("R10 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'h00C0FFEE));
        @(negedge clk);
        do_reset();

        // R1: plain ticks and idle holds
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '0, "R1 tick");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R1 idle hold");

        // R2: offset wrap
        step(1'b0, 1'b1, pack(5, 10, 3070), "R7 load");
        step(1'b1, 1'b0, '0, "R2 to 3071");
        step(1'b1, 1'b0, '0, "R2 offset wrap");

        // R3 / R5: cycle wrap into seconds, 63 -> 64 boundary event
        step(1'b0, 1'b1, pack(63, 7999, 3070), "R7 load");
        step(1'b1, 1'b0, '0, "R3 to last");
        step(1'b1, 1'b0, '0, "R5 R6 63->64 in one edge");
        step(1'b1, 1'b0, '0, "R6 event ends");

        // R4: 127 -> 0 wrap with event
        step(1'b0, 1'b1, pack(127, 7999, 3071), "R7 load top");
        step(1'b1, 1'b0, '0, "R4 R6 full wrap");
        step(1'b0, 1'b0, '0, "R6 event one cycle");

        // R6: no event on other seconds crossings
        step(1'b0, 1'b1, pack(10, 7999, 3071), "R7 load");
        step(1'b1, 1'b0, '0, "R6 no event 10->11");

        // R7: load beats tick
        step(1'b1, 1'b1, pack(3, 4, 5), "R7 load over tick");

        // R8: clamps per field, and no event on load to a boundary
        step(1'b0, 1'b1, 32'hFFFF_FFFF, "R8 clamp both");
        step(1'b0, 1'b1, pack(20, 8000, 100), "R8 clamp cycle only");
        step(1'b0, 1'b1, pack(20, 100, 3072), "R8 clamp offset only");
        step(1'b0, 1'b1, pack(64, 0, 0), "R8 load at boundary no event");
        step(1'b0, 1'b1, pack(0, 0, 0), "R8 load zero no event");

        // R10: mid-run reset
        step(1'b0, 1'b1, pack(99, 1234, 567), "R7 load");
        do_reset();

        // Random ticks and loads, loads sometimes near carries or out of range
        for (int i = 0; i < 4000; i++) begin
            rv = $urandom;
            if ($urandom_range(0, 99) < 4) begin
                if (rv[0]) rv = pack(rv[31:25], 7999, 3060 + (rv[5:1] % 12));
                step(1'b0, 1'b1, rv, "R8 random load");
            end else begin
                step($urandom_range(0, 3) != 0, 1'b0, '0, "R5 random count");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule